// File: doc/BRIEF.md
# CD Controller Indexed Register File

This block holds the sixteen byte-wide registers of a CD sector decoder's host interface. The host never addresses them directly. It first loads a 4-bit register pointer, then performs byte reads or byte writes, and each access acts on the register the pointer selects. The read side and the write side use different maps. For example, the pointer value that reads back the buffer pointer on the read side writes the word address on the write side. After most accesses the pointer steps to the next register, so the host can stream through a group of registers with a single pointer load.

Several writes do more than store a value. One write starts a data transfer, one stops it, and one acknowledges the transfer-end interrupt. These actions set or clear active-low flags in the interface status register. Reading the last status byte clears the decode interrupt. If decoding is enabled, and if every header and status register that the host is expected to read has been read since the last reset, the same read also sets the status-valid flag in that byte. The four header bytes are produced from the current disc position, which arrives as BCD minute, second and frame inputs. When sub-header mode is selected, all four header bytes read as zeros.

The surrounding logic supplies two single-cycle events. One reports that the data port has moved the last byte. The other reports that a sector has finished decoding. The block also drives one pulse that clears the end-of-transfer bit in the host mode register.

Top module: `cdc_regfile`

## Requirements
- R1: `ptr_ld` loads `ptr_ld_val` into the pointer on the next edge and takes priority over any access in that cycle. A write has priority over a read in the same cycle. Each accepted access moves the pointer up by one unless R2 applies.
- R2: The pointer holds its value after a read of index 15 and after writes to indices 6, 7, 14 and 15.
- R3: After reset the pointer is 0. The reset register values are: interface status 0xFF, header bytes minute/second/frame taken from the position inputs with mode byte 0x01, word address 0x1260 (4704), status byte 0 = 0x80, and every other register 0. `busy`, `eot_clr`, `sub_out`, `dac` and `ctrl2` are 0. Interface status bits 7, 4, 2, 1 and 0 always stay 1.
- R4: Read map by index: 0 command input (always 0); 1 interface status; 2/3 byte count low/high; 4..7 header 0..3; 8/9 buffer pointer low/high; 10/11 word address low/high; 12..15 status 0..3 (status 1 and 2 always 0). Write map by index: 0 sub-output; 1 interface control; 2/3 byte count low/high; 4/5 data address low/high; 6 transfer trigger; 7 transfer acknowledge; 8/9 word address low/high; 10 control 0; 11 control 1; 12/13 buffer pointer low/high; 14 control 2; 15 soft reset.
- R5: A write to interface control with bit 1 clear sets the byte count to 0, clears `busy`, and sets interface status bit 3.
- R6: A write to the trigger index while interface control bit 1 is set clears interface status bit 3, sets `busy`, and raises `eot_clr` for exactly one cycle, starting on the edge after the write. With control bit 1 clear, the trigger write has no effect.
- R7: A write to the acknowledge index sets interface status bit 6.
- R8: A read of status byte 3 returns the value it held before the read and sets interface status bit 5.
- R9: The block keeps a 16-bit tracking vector. A read of index i sets bit i when bit i of the mask 0x73F2 is 1. A read of status byte 3 loads 0x80 into status byte 3 only when all of the following hold: control 0 bit 7 is 1, interface control bit 5 is 1, and every mask bit is already set in the tracking vector.
- R10: With control 1 bit 0 set, header bytes 0..3 read as 0. With it clear, they read as `pos_min`, `pos_sec`, `pos_frm` and 0x01, in that order.
- R11: A write to index 15 returns every register to its R3 value, clears the tracking vector and `busy`, and leaves the pointer at 15.
- R12: Writes to sub-output, data address and control 2 appear on `sub_out`, `dac` (high byte from index 5) and `ctrl2`.
- R13: `xfer_done` is ignored while `busy` is clear. While `busy` is set, it clears `busy` and the byte count, sets interface status bit 3, and clears bit 6 if interface control bit 6 is set. `dec_event` clears interface status bit 5 when interface control bit 5 is set and is ignored otherwise. A host access in the same cycle takes priority over either event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_ld | input | 1 | Load the register pointer |
| ptr_ld_val | input | 4 | New pointer value |
| rd_en | input | 1 | Byte read of the selected register |
| wr_en | input | 1 | Byte write of the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| pos_min | input | 8 | Current position minute, BCD |
| pos_sec | input | 8 | Current position second, BCD |
| pos_frm | input | 8 | Current position frame, BCD |
| xfer_done | input | 1 | Data port reports last byte moved |
| dec_event | input | 1 | Sector decode finished |
| ptr | output | 4 | Current register pointer |
| busy | output | 1 | Transfer in progress |
| eot_clr | output | 1 | One-cycle pulse clearing the host end-of-transfer bit |
| sub_out | output | 8 | Sub-output register |
| dac | output | 16 | Data address register |
| ctrl2 | output | 8 | Control 2 register |

## Verification
The checker verifies the following on every cycle. It checks the pointer's step-or-hold rule for a write to index 0 and for the non-advancing indices. It checks that a stop write, an acknowledge write or a status-3 read leaves the expected flags on the next edge. It also checks that header reads are zero in sub-header mode, that `eot_clr` never appears without `busy`, and that the fixed status bits never drop.

Some behaviour depends on a history of earlier accesses, so only the bench's scenarios show it. This covers the correct data at every index of both maps, the status-valid rule with its accumulated read history, the full restore done by a soft reset, and the gating of the two external events.

// File: rtl/cdc_regfile_pkg.sv
package cdc_regfile_pkg;
  localparam int unsigned AW   = 4;
  localparam int unsigned NREG = 1 << AW;

  // read-side indices
  localparam logic [AW-1:0] RD_CMD_IN  = 4'h0;
  localparam logic [AW-1:0] RD_IF_STAT = 4'h1;
  localparam logic [AW-1:0] RD_CNT_LO  = 4'h2;
  localparam logic [AW-1:0] RD_CNT_HI  = 4'h3;
  localparam logic [AW-1:0] RD_HDR0    = 4'h4;
  localparam logic [AW-1:0] RD_HDR1    = 4'h5;
  localparam logic [AW-1:0] RD_HDR2    = 4'h6;
  localparam logic [AW-1:0] RD_HDR3    = 4'h7;
  localparam logic [AW-1:0] RD_BPTR_LO = 4'h8;
  localparam logic [AW-1:0] RD_BPTR_HI = 4'h9;
  localparam logic [AW-1:0] RD_WADR_LO = 4'hA;
  localparam logic [AW-1:0] RD_WADR_HI = 4'hB;
  localparam logic [AW-1:0] RD_STS0    = 4'hC;
  localparam logic [AW-1:0] RD_STS1    = 4'hD;
  localparam logic [AW-1:0] RD_STS2    = 4'hE;
  localparam logic [AW-1:0] RD_STS3    = 4'hF;

  // write-side indices
  localparam logic [AW-1:0] WR_SUB_OUT = 4'h0;
  localparam logic [AW-1:0] WR_IF_CTRL = 4'h1;
  localparam logic [AW-1:0] WR_CNT_LO  = 4'h2;
  localparam logic [AW-1:0] WR_CNT_HI  = 4'h3;
  localparam logic [AW-1:0] WR_DADR_LO = 4'h4;
  localparam logic [AW-1:0] WR_DADR_HI = 4'h5;
  localparam logic [AW-1:0] WR_TRIG    = 4'h6;
  localparam logic [AW-1:0] WR_ACK     = 4'h7;
  localparam logic [AW-1:0] WR_WADR_LO = 4'h8;
  localparam logic [AW-1:0] WR_WADR_HI = 4'h9;
  localparam logic [AW-1:0] WR_CTL0    = 4'hA;
  localparam logic [AW-1:0] WR_CTL1    = 4'hB;
  localparam logic [AW-1:0] WR_BPTR_LO = 4'hC;
  localparam logic [AW-1:0] WR_BPTR_HI = 4'hD;
  localparam logic [AW-1:0] WR_CTL2    = 4'hE;
  localparam logic [AW-1:0] WR_SRST    = 4'hF;

  // pointer hold masks, one bit per index
  localparam logic [NREG-1:0] RD_HOLD = 16'h8000;
  localparam logic [NREG-1:0] WR_HOLD = 16'hC0C0;

  // reads that feed the status-valid rule
  localparam logic [NREG-1:0] TRACK_MASK = 16'h73F2;

  // bit positions
  localparam int unsigned IFS_IDLE_N = 3;
  localparam int unsigned IFS_DEC_N  = 5;
  localparam int unsigned IFS_END_N  = 6;
  localparam int unsigned IFC_XEN    = 1;
  localparam int unsigned IFC_DECIE  = 5;
  localparam int unsigned IFC_ENDIE  = 6;
  localparam int unsigned CTL0_DECEN = 7;
  localparam int unsigned CTL1_SUBHD = 0;
endpackage

// File: rtl/cdc_ptr_ctl.sv
module cdc_ptr_ctl
  import cdc_regfile_pkg::*;
#(
  parameter logic [NREG-1:0] RD_HOLD_M = RD_HOLD,
  parameter logic [NREG-1:0] WR_HOLD_M = WR_HOLD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          rd_acc,
  input  logic          wr_acc,
  output logic [AW-1:0] ptr_q
);
  logic          adv;
  logic [AW-1:0] ptr_d;

  always_comb begin
    adv   = (rd_acc && !RD_HOLD_M[ptr_q]) || (wr_acc && !WR_HOLD_M[ptr_q]);
    ptr_d = ld ? ld_val : ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (ld || adv) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/cdc_hdr_mux.sv
module cdc_hdr_mux #(
  parameter int unsigned DW = 8
) (
  input  logic          sub_hdr,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] pos_min,
  input  logic [DW-1:0] pos_sec,
  input  logic [DW-1:0] pos_frm,
  output logic [DW-1:0] hdr_byte
);
  localparam int unsigned NB = 4;
  logic [DW-1:0] raw   [NB];
  logic [DW-1:0] gated [NB];

  assign raw[0] = pos_min;
  assign raw[1] = pos_sec;
  assign raw[2] = pos_frm;
  assign raw[3] = DW'(1);

  for (genvar g = 0; g < NB; g++) begin : g_gate
    assign gated[g] = sub_hdr ? '0 : raw[g];
  end

  assign hdr_byte = gated[sel];
endmodule

// File: rtl/cdc_regfile.sv
module cdc_regfile
  import cdc_regfile_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter logic [2*DW-1:0] WADR_RESET = 16'd4704,
  parameter logic [DW-1:0]   STS0_RESET = 8'h80,
  parameter logic [DW-1:0]   IFS_RESET  = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ptr_ld,
  input  logic [AW-1:0]   ptr_ld_val,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  input  logic [DW-1:0]   pos_min,
  input  logic [DW-1:0]   pos_sec,
  input  logic [DW-1:0]   pos_frm,
  input  logic            xfer_done,
  input  logic            dec_event,
  output logic [AW-1:0]   ptr,
  output logic            busy,
  output logic            eot_clr,
  output logic [DW-1:0]   sub_out,
  output logic [2*DW-1:0] dac,
  output logic [DW-1:0]   ctrl2
);
  localparam int unsigned WW = 2 * DW;

  typedef struct packed {
    logic [DW-1:0]   ifstat;
    logic [DW-1:0]   ifctrl;
    logic [DW-1:0]   ctrl0;
    logic [DW-1:0]   ctrl1;
    logic [DW-1:0]   ctrl2;
    logic [DW-1:0]   sbout;
    logic [DW-1:0]   sts3;
    logic [WW-1:0]   dbc;
    logic [WW-1:0]   dac;
    logic [WW-1:0]   wadr;
    logic [WW-1:0]   bptr;
    logic [NREG-1:0] track;
    logic            busy;
    logic            eot;
  } st_t;

  localparam st_t ST_RST = '{
    ifstat: IFS_RESET, ifctrl: '0, ctrl0: '0, ctrl1: '0, ctrl2: '0,
    sbout: '0, sts3: '0, dbc: '0, dac: '0, wadr: WADR_RESET, bptr: '0,
    track: '0, busy: 1'b0, eot: 1'b0
  };

  st_t           st_q, st_d;
  logic [AW-1:0] ptr_q;
  logic          rd_acc, wr_acc, st_en;
  logic [DW-1:0] hdr_byte;

  assign wr_acc = wr_en && !ptr_ld;
  assign rd_acc = rd_en && !wr_en && !ptr_ld;

  cdc_ptr_ctl u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ptr_ld),
    .ld_val(ptr_ld_val),
    .rd_acc(rd_acc),
    .wr_acc(wr_acc),
    .ptr_q (ptr_q)
  );

  cdc_hdr_mux #(.DW(DW)) u_hdr (
    .sub_hdr (st_q.ctrl1[CTL1_SUBHD]),
    .sel     (ptr_q[1:0]),
    .pos_min (pos_min),
    .pos_sec (pos_sec),
    .pos_frm (pos_frm),
    .hdr_byte(hdr_byte)
  );

  // next state: external events first, host access overrides
  always_comb begin
    st_d     = st_q;
    st_d.eot = 1'b0;

    if (xfer_done && st_q.busy) begin
      st_d.busy               = 1'b0;
      st_d.dbc                = '0;
      st_d.ifstat[IFS_IDLE_N] = 1'b1;
      if (st_q.ifctrl[IFC_ENDIE]) st_d.ifstat[IFS_END_N] = 1'b0;
    end
    if (dec_event && st_q.ifctrl[IFC_DECIE]) st_d.ifstat[IFS_DEC_N] = 1'b0;

    if (rd_acc) begin
      if (TRACK_MASK[ptr_q]) st_d.track[ptr_q] = 1'b1;
      if (ptr_q == RD_STS3) begin
        st_d.ifstat[IFS_DEC_N] = 1'b1;
        if (st_q.ctrl0[CTL0_DECEN] && st_q.ifctrl[IFC_DECIE] &&
            ((st_q.track & TRACK_MASK) == TRACK_MASK))
          st_d.sts3 = DW'(8'h80);
      end
    end

    if (wr_acc) begin
      unique case (ptr_q)
        WR_SUB_OUT: st_d.sbout = wr_data;
        WR_IF_CTRL: begin
          st_d.ifctrl = wr_data;
          if (!wr_data[IFC_XEN]) begin
            st_d.dbc                = '0;
            st_d.busy               = 1'b0;
            st_d.ifstat[IFS_IDLE_N] = 1'b1;
          end
        end
        WR_CNT_LO:  st_d.dbc[DW-1:0]   = wr_data;
        WR_CNT_HI:  st_d.dbc[WW-1:DW]  = wr_data;
        WR_DADR_LO: st_d.dac[DW-1:0]   = wr_data;
        WR_DADR_HI: st_d.dac[WW-1:DW]  = wr_data;
        WR_TRIG: begin
          if (st_q.ifctrl[IFC_XEN]) begin
            st_d.ifstat[IFS_IDLE_N] = 1'b0;
            st_d.busy               = 1'b1;
            st_d.eot                = 1'b1;
          end
        end
        WR_ACK:     st_d.ifstat[IFS_END_N] = 1'b1;
        WR_WADR_LO: st_d.wadr[DW-1:0]  = wr_data;
        WR_WADR_HI: st_d.wadr[WW-1:DW] = wr_data;
        WR_CTL0:    st_d.ctrl0 = wr_data;
        WR_CTL1:    st_d.ctrl1 = wr_data;
        WR_BPTR_LO: st_d.bptr[DW-1:0]  = wr_data;
        WR_BPTR_HI: st_d.bptr[WW-1:DW] = wr_data;
        WR_CTL2:    st_d.ctrl2 = wr_data;
        WR_SRST:    st_d = ST_RST;
        default:    st_d = st_q;
      endcase
    end
  end

  assign st_en = rd_acc || wr_acc || xfer_done || dec_event || st_q.eot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_RST;
    else if (st_en) st_q <= st_d;
  end

  // read map
  always_comb begin
    unique case (ptr_q)
      RD_CMD_IN:  rd_data = '0;
      RD_IF_STAT: rd_data = st_q.ifstat;
      RD_CNT_LO:  rd_data = st_q.dbc[DW-1:0];
      RD_CNT_HI:  rd_data = st_q.dbc[WW-1:DW];
      RD_HDR0, RD_HDR1, RD_HDR2, RD_HDR3: rd_data = hdr_byte;
      RD_BPTR_LO: rd_data = st_q.bptr[DW-1:0];
      RD_BPTR_HI: rd_data = st_q.bptr[WW-1:DW];
      RD_WADR_LO: rd_data = st_q.wadr[DW-1:0];
      RD_WADR_HI: rd_data = st_q.wadr[WW-1:DW];
      RD_STS0:    rd_data = STS0_RESET;
      RD_STS1, RD_STS2: rd_data = '0;
      RD_STS3:    rd_data = st_q.sts3;
      default:    rd_data = '0;
    endcase
  end

  assign ptr     = ptr_q;
  assign busy    = st_q.busy;
  assign eot_clr = st_q.eot;
  assign sub_out = st_q.sbout;
  assign dac     = st_q.dac;
  assign ctrl2   = st_q.ctrl2;
endmodule

// File: rtl/cdc_regfile_chk.sv
module cdc_regfile_chk
  import cdc_regfile_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ptr_ld,
  input logic [AW-1:0]   ptr_ld_val,
  input logic            rd_en,
  input logic            wr_en,
  input logic            xen_bit,
  input logic [AW-1:0]   ptr,
  input logic            busy,
  input logic            eot_clr,
  input logic [DW-1:0]   rd_data,
  input logic [DW-1:0]   ifstat,
  input logic            sub_hdr,
  input logic [2*DW-1:0] dbc
);
  logic wr_acc, rd_acc;
  assign wr_acc = wr_en && !ptr_ld;
  assign rd_acc = rd_en && !wr_en && !ptr_ld;

  // R1
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> ptr == $past(ptr_ld_val));

  // R1
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && ptr == 4'h0) |=> ptr == 4'h1);

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && ptr == 4'hF) |=> $stable(ptr));

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (ptr == 4'h6 || ptr == 4'h7 || ptr == 4'hE || ptr == 4'hF))
      |=> $stable(ptr));

  // R3
  ifstat_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ifstat & 8'h97) == 8'h97);

  // R5
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && ptr == 4'h1 && !xen_bit) |=> (!busy && dbc == '0 && ifstat[IFS_IDLE_N]));

  // R6
  eot_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_clr |-> busy);

  // R7
  ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && ptr == 4'h7) |=> ifstat[IFS_END_N]);

  // R8
  sts3_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && ptr == 4'hF) |=> ifstat[IFS_DEC_N]);

  // R10
  subhdr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_hdr && ptr[3:2] == 2'b01) |-> rd_data == '0);
endmodule

bind cdc_regfile cdc_regfile_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ptr_ld    (ptr_ld),
  .ptr_ld_val(ptr_ld_val),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .xen_bit   (wr_data[1]),
  .ptr       (ptr),
  .busy      (busy),
  .eot_clr   (eot_clr),
  .rd_data   (rd_data),
  .ifstat    (st_q.ifstat),
  .sub_hdr   (st_q.ctrl1[0]),
  .dbc       (st_q.dbc)
);

// File: tb/cdc_regfile_tb.sv
module cdc_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk, rst_n;
  logic          ptr_ld, rd_en, wr_en, xfer_done, dec_event;
  logic [3:0]    ptr_ld_val;
  logic [DW-1:0] wr_data, rd_data, pos_min, pos_sec, pos_frm;
  logic [3:0]    ptr;
  logic          busy, eot_clr;
  logic [DW-1:0] sub_out, ctrl2;
  logic [15:0]   dac;

  cdc_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_ld_val(ptr_ld_val),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pos_min(pos_min), .pos_sec(pos_sec), .pos_frm(pos_frm),
    .xfer_done(xfer_done), .dec_event(dec_event), .ptr(ptr), .busy(busy),
    .eot_clr(eot_clr), .sub_out(sub_out), .dac(dac), .ctrl2(ctrl2)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops one expected item per read strobe
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL read without expectation act=%0h exp=none", rd_data);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (rd_data !== it.exp) begin
          errors++;
          $display("FAIL %s act=%0h exp=%0h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_ptr(input logic [3:0] p);
    ptr_ld = 1'b1; ptr_ld_val = p; step(); ptr_ld = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; step(); rd_en = 1'b0;
  endtask

  task automatic pulse_done();
    xfer_done = 1'b1; step(); xfer_done = 1'b0;
  endtask

  task automatic pulse_dec();
    dec_event = 1'b1; step(); dec_event = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ptr_ld = 0; ptr_ld_val = 0; rd_en = 0; wr_en = 0; wr_data = 0;
    xfer_done = 0; dec_event = 0;
    pos_min = 8'h12; pos_sec = 8'h34; pos_frm = 8'h56;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // reset state
    chk(ptr, 0, "R3 pointer");
    chk(busy, 0, "R3 busy");
    chk(eot_clr, 0, "R3 eot_clr");
    chk(dac, 0, "R3 dac");
    chk(sub_out, 0, "R3 sub_out");
    chk(ctrl2, 0, "R3 ctrl2");

    // full sweep of the read map, pointer advancing
    rd(8'h00, "R4 cmd in");
    rd(8'hFF, "R3 ifstat");
    rd(8'h00, "R3 count lo");
    rd(8'h00, "R3 count hi");
    rd(8'h12, "R10 hdr minute");
    rd(8'h34, "R10 hdr second");
    rd(8'h56, "R10 hdr frame");
    rd(8'h01, "R10 hdr mode");
    rd(8'h00, "R3 bptr lo");
    rd(8'h00, "R3 bptr hi");
    rd(8'h60, "R3 wadr lo");
    rd(8'h12, "R3 wadr hi");
    rd(8'h80, "R3 sts0");
    rd(8'h00, "R4 sts1");
    rd(8'h00, "R4 sts2");
    rd(8'h00, "R3 sts3");
    chk(ptr, 4'hF, "R2 read F holds");
    rd(8'h00, "R2 sts3 again");
    chk(ptr, 4'hF, "R2 read F holds again");

    // write map
    set_ptr(4'h2);
    chk(ptr, 4'h2, "R1 pointer load");
    wr(8'h34); wr(8'h02);
    chk(ptr, 4'h4, "R1 write advance");
    wr(8'hCD); wr(8'hAB);
    chk(dac, 16'hABCD, "R12 dac");
    chk(ptr, 4'h6, "R1 advance to trigger");
    set_ptr(4'h8);
    wr(8'h11); wr(8'h22); wr(8'h00); wr(8'h01); wr(8'h78); wr(8'h56);
    chk(ptr, 4'hE, "R1 advance to ctrl2");
    wr(8'h5A);
    chk(ptr, 4'hE, "R2 ctrl2 write holds");
    chk(ctrl2, 8'h5A, "R12 ctrl2");
    set_ptr(4'h0);
    wr(8'h3C);
    chk(sub_out, 8'h3C, "R12 sub_out");
    chk(ptr, 4'h1, "R1 sub_out advance");
    set_ptr(4'h2);
    rd(8'h34, "R4 count lo");
    rd(8'h02, "R4 count hi");
    rd(8'h00, "R10 subhdr 0");
    rd(8'h00, "R10 subhdr 1");
    rd(8'h00, "R10 subhdr 2");
    rd(8'h00, "R10 subhdr 3");
    rd(8'h78, "R4 bptr lo");
    rd(8'h56, "R4 bptr hi");
    rd(8'h11, "R4 wadr lo");
    rd(8'h22, "R4 wadr hi");

    // transfer start and completion
    set_ptr(4'h1); wr(8'h02);
    set_ptr(4'h6); wr(8'h00);
    chk(eot_clr, 1, "R6 eot pulse");
    chk(busy, 1, "R6 busy");
    chk(ptr, 4'h6, "R2 trigger holds");
    step();
    chk(eot_clr, 0, "R6 eot one cycle");
    set_ptr(4'h1);
    rd(8'hF7, "R6 ifstat busy");
    pulse_done();
    chk(busy, 0, "R13 done clears busy");
    set_ptr(4'h1);
    rd(8'hFF, "R13 ifstat idle");
    rd(8'h00, "R13 count lo cleared");
    rd(8'h00, "R13 count hi cleared");

    // end interrupt and acknowledge
    set_ptr(4'h1); wr(8'h42);
    set_ptr(4'h6); wr(8'h00);
    pulse_done();
    set_ptr(4'h1);
    rd(8'hBF, "R13 end flag");
    set_ptr(4'h7); wr(8'h00);
    chk(ptr, 4'h7, "R2 ack holds");
    set_ptr(4'h1);
    rd(8'hFF, "R7 ack sets bit 6");

    // stop by control write
    set_ptr(4'h2); wr(8'h10); wr(8'h00);
    set_ptr(4'h6); wr(8'h00);
    chk(busy, 1, "R6 busy again");
    set_ptr(4'h1); wr(8'h00);
    chk(busy, 0, "R5 stop clears busy");
    set_ptr(4'h1);
    rd(8'hFF, "R5 ifstat after stop");
    rd(8'h00, "R5 count lo");
    rd(8'h00, "R5 count hi");

    // trigger with transfers disabled
    set_ptr(4'h6); wr(8'h00);
    chk(busy, 0, "R6 disabled trigger busy");
    chk(eot_clr, 0, "R6 disabled trigger eot");
    set_ptr(4'h1);
    rd(8'hFF, "R6 disabled trigger ifstat");

    // done while idle
    set_ptr(4'h2); wr(8'h44); wr(8'h00);
    pulse_done();
    set_ptr(4'h2);
    rd(8'h44, "R13 done ignored idle");

    // soft reset
    set_ptr(4'h1); wr(8'h02);
    set_ptr(4'h6); wr(8'h00);
    set_ptr(4'hF); wr(8'h00);
    chk(busy, 0, "R11 busy cleared");
    chk(ptr, 4'hF, "R11 pointer stays");
    chk(dac, 0, "R11 dac");
    chk(sub_out, 0, "R11 sub_out");
    chk(ctrl2, 0, "R11 ctrl2");
    set_ptr(4'h1);
    rd(8'hFF, "R11 ifstat");
    rd(8'h00, "R11 count lo");
    rd(8'h00, "R11 count hi");
    set_ptr(4'hA);
    rd(8'h60, "R11 wadr lo");
    rd(8'h12, "R11 wadr hi");

    // decode interrupt and status-valid rule
    set_ptr(4'h1); wr(8'h20);
    set_ptr(4'hA); wr(8'h80);
    pulse_dec();
    set_ptr(4'h1);
    rd(8'hDF, "R13 decode flag");
    set_ptr(4'hF);
    rd(8'h00, "R8 sts3 old value");
    rd(8'h00, "R9 tracking incomplete");
    set_ptr(4'h1);
    rd(8'hFF, "R8 decode flag cleared");
    rd(8'h00, "R4 count lo");
    rd(8'h00, "R4 count hi");
    rd(8'h12, "R10 hdr minute");
    rd(8'h34, "R10 hdr second");
    rd(8'h56, "R10 hdr frame");
    rd(8'h01, "R10 hdr mode");
    rd(8'h00, "R4 bptr lo");
    rd(8'h00, "R4 bptr hi");
    rd(8'h60, "R4 wadr lo");
    rd(8'h12, "R4 wadr hi");
    rd(8'h80, "R4 sts0");
    rd(8'h00, "R4 sts1");
    rd(8'h00, "R4 sts2");
    rd(8'h00, "R9 sts3 returns old");
    rd(8'h80, "R9 sts3 valid");

    // decode event with interrupt disabled
    set_ptr(4'h1); wr(8'h00);
    pulse_dec();
    set_ptr(4'h1);
    rd(8'hFF, "R13 decode ignored");

    step();
    chk(sb_q.size(), 0, "R4 scoreboard drained");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule